// File: doc/BRIEF.md
# RAM-Set Code Buffer

This block is a 4 KB buffer that holds one contiguous, 4 KB-aligned region of program code. It sits next to a set-associative instruction cache. A single range tag names the region the buffer currently stands for. Each of its 256 lines of four 32-bit words becomes valid only after it has been filled from external memory. A fetch whose upper address bits equal the tag is served here. A fetch outside the region is reported as a miss, so the surrounding cache logic can look elsewhere.

Software chooses whether the buffer is used. It does this with a configuration input that is sampled only while the cache is switched off. Writing a new tag, or a global flush, invalidates every line at once. Fetch requests, fetch responses and line-fill traffic are all valid/ready streams. A sender holds valid and its payload steady until it sees ready. The block holds `r_valid`, `r_hit` and `r_data` until `r_ready` is high. The external memory may stall the fill request by holding `fill_req_ready` low. It may stall the fill data by holding `fill_dvalid` low. The block accepts one fetch at a time: `f_ready` is high only while no fetch is in progress.

Top module: `ramset_code_buf`

## Requirements
- R1: After reset, no line is valid, the buffer is not in use, `f_ready` is 1, and `r_valid` and `fill_req_valid` are 0.
- R2: A 24-bit byte fetch address is split into a range tag in bits 23:12, a line index in bits 11:4 and a word select in bits 3:2. Bits 1:0 are ignored.
- R3: A fetch hits when three things hold: the buffer is in use, the address tag equals the tag register, and the indexed line is valid. A hit returns `r_hit`=1 and the stored word, and it issues no line fill.
- R4: A fetch with a matching tag to an invalid line issues exactly one fill request at the line-aligned address (bits 3:0 zero). It then accepts four data beats, in word order 0 to 3, into that line. It answers with `r_hit`=1 and the requested word, and after that the line is valid.
- R5: A fetch whose tag differs from the tag register answers `r_hit`=0 with `r_data`=0 and issues no fill. Lines that were valid stay valid.
- R6: While the buffer is not in use, every fetch answers `r_hit`=0 and issues no fill, even when the address tag equals the tag register.
- R7: The use setting `cfg_use` is captured only while `cache_on` is 0. Changes to it while `cache_on` is 1 have no effect.
- R8: A tag write loads the new tag and clears every line-valid bit in the cycle it is applied.
- R9: A flush clears every line-valid bit and keeps the tag value.
- R10: `f_ready` is 0 while a fetch is in progress. The response and the fill request each hold their valid and payload steady until accepted.
- R11: A flush or tag write that arrives while a line fill is in progress leaves that line invalid. The fetch itself still completes with `r_hit`=1 and the word that was filled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cache_on | input | 1 | Cache enabled; while 1, the use setting is frozen |
| cfg_use | input | 1 | Use this buffer (sampled while cache_on is 0) |
| tag_wr | input | 1 | Load tag_wdata into the tag register and clear all lines |
| tag_wdata | input | 12 | New range tag |
| flush | input | 1 | Clear all line-valid bits |
| f_valid | input | 1 | Fetch request valid |
| f_ready | output | 1 | Fetch request accepted |
| f_addr | input | 24 | Fetch byte address |
| r_valid | output | 1 | Response valid |
| r_ready | input | 1 | Response accepted |
| r_hit | output | 1 | The buffer served the fetch |
| r_data | output | 32 | Fetched word (0 on a miss) |
| fill_req_valid | output | 1 | Line fill request valid |
| fill_req_ready | input | 1 | Line fill request accepted |
| fill_addr | output | 24 | Line-aligned fill address |
| fill_dvalid | input | 1 | Fill data beat valid |
| fill_dready | output | 1 | Fill data beat accepted |
| fill_data | input | 32 | Fill data beat |

## Verification
A line-valid bit left set by mistake shows up at the very next fetch to that line. That fetch answers with `r_hit` high and no fill request, and it returns whatever word was stored before. This is why every fetch is checked for both the data word and the number of fill requests. A bit lost by mistake shows the opposite way on the next fetch: an extra fill request. A wrong tag or use state turns hits into misses, or misses into hits, in the one response that follows the fetch handshake. A fill that lands in the wrong word slot is caught by a later hit to the neighbouring word in the same line.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_FILL = 2'd2,
    ST_RESP = 2'd3
  } rsb_state_e;
endpackage

// File: rtl/rsb_valid_bits.sv
module rsb_valid_bits #(
  parameter int LINES = 256,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_all,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic             any_valid
);
  logic [LINES-1:0] vld_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       vld_q <= '0;
    else if (clr_all) vld_q <= '0;           // clear wins over a same-cycle set
    else if (set_en)  vld_q[set_idx] <= 1'b1;
  end

  assign rd_valid  = vld_q[rd_idx];
  assign any_valid = |vld_q;
endmodule

// File: rtl/rsb_data_store.sv
module rsb_data_store #(
  parameter int LINES  = 256,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  localparam int IDX_W  = $clog2(LINES),
  localparam int WSEL_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_line,
  input  logic [WSEL_W-1:0] wr_word,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_line,
  input  logic [WSEL_W-1:0] rd_word,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [LINES*WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[{wr_line, wr_word}] <= wr_data;
  end

  assign rd_data = mem[{rd_line, rd_word}];
endmodule

// File: rtl/rsb_ctrl.sv
module rsb_ctrl
  import rsb_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int LINES  = 256,
  parameter int WORDS  = 4,
  localparam int IDX_W  = $clog2(LINES),
  localparam int WSEL_W = $clog2(WORDS),
  localparam int OFS_W  = WSEL_W + 2,
  localparam int TAG_W  = ADDR_W - IDX_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic [TAG_W-1:0]  tag_q,
  input  logic              clr_evt,
  // fetch stream
  input  logic              f_valid,
  output logic              f_ready,
  input  logic [ADDR_W-1:0] f_addr,
  output logic              r_valid,
  input  logic              r_ready,
  output logic              r_hit,
  output logic [DATA_W-1:0] r_data,
  // storage side
  input  logic              line_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic [IDX_W-1:0]  rd_line,
  output logic [WSEL_W-1:0] rd_word,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_line,
  output logic [WSEL_W-1:0] wr_word,
  output logic [DATA_W-1:0] wr_data,
  output logic              set_valid,
  output logic [IDX_W-1:0]  set_idx,
  // line fill
  output logic              fill_req_valid,
  input  logic              fill_req_ready,
  output logic [ADDR_W-1:0] fill_addr,
  input  logic              fill_dvalid,
  output logic              fill_dready,
  input  logic [DATA_W-1:0] fill_data
);
  rsb_state_e        st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WSEL_W-1:0] beat_q;
  logic              killed_q;
  logic              hit_q;
  logic [DATA_W-1:0] data_q;

  logic              tag_eq;
  logic              beat_fire;
  logic              last_beat;
  logic [IDX_W-1:0]  idx_q;
  logic [WSEL_W-1:0] wsel_q;
  logic [1:0]        unused_lsb;

  assign tag_eq     = active && (f_addr[ADDR_W-1 -: TAG_W] == tag_q);
  assign idx_q      = addr_q[OFS_W +: IDX_W];
  assign wsel_q     = addr_q[2 +: WSEL_W];
  assign unused_lsb = addr_q[1:0];

  assign f_ready        = (st_q == ST_IDLE);
  assign r_valid        = (st_q == ST_RESP);
  assign r_hit          = hit_q;
  assign r_data         = data_q;
  assign fill_req_valid = (st_q == ST_REQ);
  assign fill_addr      = {addr_q[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
  assign fill_dready    = (st_q == ST_FILL);

  assign rd_line = f_addr[OFS_W +: IDX_W];
  assign rd_word = f_addr[2 +: WSEL_W];

  assign beat_fire = fill_dready && fill_dvalid;
  assign last_beat = (beat_q == WSEL_W'(WORDS - 1));

  assign wr_en     = beat_fire;
  assign wr_line   = idx_q;
  assign wr_word   = beat_q;
  assign wr_data   = fill_data;
  assign set_valid = beat_fire && last_beat && !killed_q && !clr_evt;
  assign set_idx   = idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      addr_q   <= '0;
      beat_q   <= '0;
      killed_q <= 1'b0;
      hit_q    <= 1'b0;
      data_q   <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (f_valid) begin
            addr_q   <= f_addr;
            beat_q   <= '0;
            killed_q <= clr_evt;
            if (tag_eq && line_valid) begin
              hit_q  <= 1'b1;
              data_q <= rd_data;
              st_q   <= ST_RESP;
            end else if (tag_eq) begin
              st_q   <= ST_REQ;
            end else begin
              hit_q  <= 1'b0;
              data_q <= '0;
              st_q   <= ST_RESP;
            end
          end
        end
        ST_REQ: begin
          if (clr_evt) killed_q <= 1'b1;
          if (fill_req_ready) st_q <= ST_FILL;
        end
        ST_FILL: begin
          if (clr_evt) killed_q <= 1'b1;
          if (beat_fire) begin
            if (beat_q == wsel_q) data_q <= fill_data;
            beat_q <= beat_q + 1'b1;
            if (last_beat) begin
              hit_q <= 1'b1;
              st_q  <= ST_RESP;
            end
          end
        end
        ST_RESP: begin
          if (r_ready) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ramset_code_buf.sv
module ramset_code_buf #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int LINES  = 256,
  parameter int WORDS  = 4,
  localparam int IDX_W  = $clog2(LINES),
  localparam int WSEL_W = $clog2(WORDS),
  localparam int OFS_W  = WSEL_W + 2,
  localparam int TAG_W  = ADDR_W - IDX_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cache_on,
  input  logic              cfg_use,
  input  logic              tag_wr,
  input  logic [TAG_W-1:0]  tag_wdata,
  input  logic              flush,
  input  logic              f_valid,
  output logic              f_ready,
  input  logic [ADDR_W-1:0] f_addr,
  output logic              r_valid,
  input  logic              r_ready,
  output logic              r_hit,
  output logic [DATA_W-1:0] r_data,
  output logic              fill_req_valid,
  input  logic              fill_req_ready,
  output logic [ADDR_W-1:0] fill_addr,
  input  logic              fill_dvalid,
  output logic              fill_dready,
  input  logic [DATA_W-1:0] fill_data
);
  logic              active_q;
  logic [TAG_W-1:0]  tag_q;
  logic              clr_evt;
  logic              line_valid;
  logic              any_valid;
  logic [DATA_W-1:0] rd_data;
  logic [IDX_W-1:0]  rd_line;
  logic [WSEL_W-1:0] rd_word;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_line;
  logic [WSEL_W-1:0] wr_word;
  logic [DATA_W-1:0] wr_data;
  logic              set_valid;
  logic [IDX_W-1:0]  set_idx;

  assign clr_evt = tag_wr || flush;

  // use setting frozen while the cache runs; tag loads any time
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      tag_q    <= '0;
    end else begin
      if (!cache_on) active_q <= cfg_use;
      if (tag_wr)    tag_q    <= tag_wdata;
    end
  end

  rsb_valid_bits #(.LINES(LINES)) u_valid (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_all  (clr_evt),
    .set_en   (set_valid),
    .set_idx  (set_idx),
    .rd_idx   (rd_line),
    .rd_valid (line_valid),
    .any_valid(any_valid)
  );

  rsb_data_store #(.LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W)) u_store (
    .clk    (clk),
    .wr_en  (wr_en),
    .wr_line(wr_line),
    .wr_word(wr_word),
    .wr_data(wr_data),
    .rd_line(rd_line),
    .rd_word(rd_word),
    .rd_data(rd_data)
  );

  rsb_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .WORDS(WORDS)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .active        (active_q),
    .tag_q         (tag_q),
    .clr_evt       (clr_evt),
    .f_valid       (f_valid),
    .f_ready       (f_ready),
    .f_addr        (f_addr),
    .r_valid       (r_valid),
    .r_ready       (r_ready),
    .r_hit         (r_hit),
    .r_data        (r_data),
    .line_valid    (line_valid),
    .rd_data       (rd_data),
    .rd_line       (rd_line),
    .rd_word       (rd_word),
    .wr_en         (wr_en),
    .wr_line       (wr_line),
    .wr_word       (wr_word),
    .wr_data       (wr_data),
    .set_valid     (set_valid),
    .set_idx       (set_idx),
    .fill_req_valid(fill_req_valid),
    .fill_req_ready(fill_req_ready),
    .fill_addr     (fill_addr),
    .fill_dvalid   (fill_dvalid),
    .fill_dready   (fill_dready),
    .fill_data     (fill_data)
  );
endmodule

// File: rtl/rsb_checker.sv
module rsb_checker #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              tag_wr,
  input logic              active_q,
  input logic              any_valid,
  input logic              f_valid,
  input logic              f_ready,
  input logic              r_valid,
  input logic              r_ready,
  input logic              r_hit,
  input logic [DATA_W-1:0] r_data,
  input logic              fill_req_valid,
  input logic              fill_req_ready,
  input logic [ADDR_W-1:0] fill_addr
);
  p_fill_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req_valid && !fill_req_ready |=> fill_req_valid && $stable(fill_addr));

  p_resp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    r_valid && !r_ready |=> r_valid && $stable(r_hit) && $stable(r_data));

  p_busy_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    f_ready |-> !r_valid && !fill_req_valid);

  p_fill_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req_valid |-> fill_addr[3:0] == 4'h0);

  p_unused_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
    f_valid && f_ready && !active_q |=> r_valid && !r_hit && !fill_req_valid);

  p_clear_all_r8_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tag_wr || flush |=> !any_valid);
endmodule

bind ramset_code_buf rsb_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .flush         (flush),
  .tag_wr        (tag_wr),
  .active_q      (active_q),
  .any_valid     (any_valid),
  .f_valid       (f_valid),
  .f_ready       (f_ready),
  .r_valid       (r_valid),
  .r_ready       (r_ready),
  .r_hit         (r_hit),
  .r_data        (r_data),
  .fill_req_valid(fill_req_valid),
  .fill_req_ready(fill_req_ready),
  .fill_addr     (fill_addr)
);

// File: tb/ramset_code_buf_test.sv
`timescale 1ns/1ps
module ramset_code_buf_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cache_on = 1'b0, cfg_use = 1'b0, tag_wr = 1'b0, flush = 1'b0;
  logic [11:0] tag_wdata = '0;
  logic        f_valid = 1'b0, r_ready = 1'b0, fill_req_ready = 1'b0, fill_dvalid = 1'b0;
  logic [23:0] f_addr = '0;
  logic [31:0] fill_data = '0;
  logic        f_ready, r_valid, r_hit, fill_req_valid, fill_dready;
  logic [31:0] r_data;
  logic [23:0] fill_addr;

  int n_chk = 0, n_bad = 0;
  logic        got_hit;
  logic [31:0] got_data;
  logic [23:0] got_faddr;
  int          got_fills;
  bit          hs_ok;

  always #4 clk = ~clk;  // 125 MHz

  ramset_code_buf uut (.*);

  function automatic logic [31:0] model(input logic [23:0] a);
    return {8'hC0, a[23:2], 2'b00};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_fetch(input logic [23:0] a, input int dly, input int fl_beat);
    int beat = 0, rwait = 0, qwait = 0;
    bit done = 0;
    got_fills = 0; got_hit = 0; got_data = '0; got_faddr = '0; hs_ok = 1;
    @(negedge clk); f_valid = 1'b1; f_addr = a;
    @(posedge clk); #1; f_valid = 1'b0;
    for (int i = 0; i < 80 && !done; i++) begin
      @(negedge clk);
      flush = 1'b0; fill_req_ready = 1'b0; fill_dvalid = 1'b0;
      if (f_ready) hs_ok = 0;
      if (r_valid) begin
        if (rwait == 0) begin got_hit = r_hit; got_data = r_data; end
        else if (r_hit !== got_hit || r_data !== got_data) hs_ok = 0;
        if (rwait >= dly) begin
          r_ready = 1'b1; @(posedge clk); #1; r_ready = 1'b0; done = 1;
        end
        rwait++;
      end else if (fill_req_valid) begin
        if (qwait == 0) got_faddr = fill_addr;
        else if (fill_addr !== got_faddr) hs_ok = 0;
        if (qwait >= dly) begin fill_req_ready = 1'b1; got_fills++; end
        qwait++;
      end else if (fill_dready) begin
        fill_dvalid = 1'b1;
        fill_data   = model(got_faddr + 24'(4 * beat));
        if (beat == fl_beat) flush = 1'b1;
        beat++;
      end
    end
    if (!done) hs_ok = 0;
    @(negedge clk); flush = 1'b0; fill_req_ready = 1'b0; fill_dvalid = 1'b0;
  endtask

  task automatic expect_fetch(input logic [23:0] a, input bit hit, input int fills, input string req);
    logic [31:0] ed;
    ed = hit ? model({a[23:2], 2'b00}) : 32'h0;
    check(got_hit === hit, req, {31'h0, got_hit}, {31'h0, hit});
    check(got_data === ed, req, got_data, ed);
    check(got_fills == fills, req, got_fills, fills);
    if (fills > 0)
      check(got_faddr === {a[23:4], 4'h0}, req, {8'h0, got_faddr}, {8'h0, a[23:4], 4'h0});
  endtask

  task automatic write_tag(input logic [11:0] t);
    @(negedge clk); tag_wr = 1'b1; tag_wdata = t;
    @(negedge clk); tag_wr = 1'b0;
  endtask

  typedef struct packed {
    logic [23:0] a;
    logic        hit;
    logic [1:0]  fills;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{24'h123040, 1'b1, 2'd1},  // R4 first touch fills
    '{24'h12304C, 1'b1, 2'd0},  // R3 same line, word 3
    '{24'h123048, 1'b1, 2'd0},  // R3 word 2
    '{24'h456040, 1'b0, 2'd0},  // R5 other region
    '{24'h123044, 1'b1, 2'd0},  // R5 previous line kept
    '{24'h123FF8, 1'b1, 2'd1},  // R2 last line
    '{24'h123FF3, 1'b1, 2'd0},  // R2 low bits ignored
    '{24'h124040, 1'b0, 2'd0},  // R2 region above
    '{24'h122FFC, 1'b0, 2'd0},  // R2 region below
    '{24'h123000, 1'b1, 2'd1}   // R4 first line
  };

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(f_ready === 1'b1, "R1 f_ready", {31'h0, f_ready}, 32'h1);
    check(r_valid === 1'b0 && fill_req_valid === 1'b0, "R1 idle outputs",
          {30'h0, r_valid, fill_req_valid}, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    // R6 / R1: reset tag is 0, buffer not in use -> miss
    do_fetch(24'h000040, 0, -1);
    expect_fetch(24'h000040, 1'b0, 0, "R6 unused buffer");

    @(negedge clk); cfg_use = 1'b1;
    write_tag(12'h123);
    @(negedge clk); cache_on = 1'b1;

    foreach (VECS[i]) begin
      do_fetch(VECS[i].a, 0, -1);
      expect_fetch(VECS[i].a, VECS[i].hit, int'(VECS[i].fills), "R3/R4/R5 vector");
      check(hs_ok, "R10 handshake", {31'h0, hs_ok}, 32'h1);
    end

    // R7: change ignored while cache on
    @(negedge clk); cfg_use = 1'b0;
    do_fetch(24'h123040, 0, -1);
    expect_fetch(24'h123040, 1'b1, 0, "R7 frozen use");
    @(negedge clk); cache_on = 1'b0;
    @(negedge clk); cache_on = 1'b1;
    do_fetch(24'h123040, 0, -1);
    expect_fetch(24'h123040, 1'b0, 0, "R7 captured off");
    @(negedge clk); cache_on = 1'b0; cfg_use = 1'b1;
    @(negedge clk); cache_on = 1'b1;
    do_fetch(24'h123040, 0, -1);
    expect_fetch(24'h123040, 1'b1, 0, "R7 lines kept");

    // R9: flush keeps tag
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    do_fetch(24'h123044, 0, -1);
    expect_fetch(24'h123044, 1'b1, 1, "R9 flush refills");

    // R8: tag write
    write_tag(12'h456);
    do_fetch(24'h456FF4, 0, -1);
    expect_fetch(24'h456FF4, 1'b1, 1, "R8 new tag");
    do_fetch(24'h123FF0, 0, -1);
    expect_fetch(24'h123FF0, 1'b0, 0, "R8 old tag misses");
    write_tag(12'h123);
    do_fetch(24'h123000, 0, -1);
    expect_fetch(24'h123000, 1'b1, 1, "R8 lines cleared");

    // R10: stalls on fill request and response
    do_fetch(24'h1230A8, 3, -1);
    expect_fetch(24'h1230A8, 1'b1, 1, "R10 stalled fill");
    check(hs_ok, "R10 hold under stall", {31'h0, hs_ok}, 32'h1);

    // R11: flush during fill
    do_fetch(24'h123084, 0, 1);
    expect_fetch(24'h123084, 1'b1, 1, "R11 fetch completes");
    do_fetch(24'h123088, 0, -1);
    expect_fetch(24'h123088, 1'b1, 1, "R11 line left invalid");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule